// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder

This block lets a small on-chip memory answer an asynchronous extended-data-out DRAM bus as if it were a real DRAM. It samples the four active-low strobes (row strobe, column strobe, write enable, output enable) with a fast local clock through two-flop synchronisers. From the order in which the strobe edges arrive it works out what kind of memory cycle the host is running. It latches the row address on the row-strobe edge and the column address on each column-strobe edge. It then reads or writes a parameterised internal array and drives the data pins with extended-data-out hold behaviour.

The bus is paced by its strobes alone. It has no valid/ready handshake and the block cannot apply back-pressure, so the host must hold each pin level for at least four clock periods. The address and data pins pass through the same two-stage synchroniser as the strobes, so each value is seen together with the strobe edge that qualifies it. Array contents are undefined until written. The column address uses the low `COL_W` bits of the address pins, and `COL_W` must not exceed `ROW_W`.

Top module: `edo_cycle_decoder`

## Requirements
- R1: While reset is held and just after it is released, `cyc_type` is 0 (idle) and `dq_oe`, `test_mode`, `arr_wr` and `arr_rd` are all 0.
- R2: If the column strobe is already active when the row strobe becomes active, with write enable inactive and no read data held, `cyc_type` becomes 6 (refresh with column first). The address pins are ignored and the array is not accessed.
- R3: If both the column strobe and write enable are active when the row strobe becomes active, `cyc_type` becomes 8 (test entry) and `test_mode` becomes 1. A later refresh-with-column-first cycle or a row-only cycle clears `test_mode`.
- R4: A row strobe that is asserted and then released with no column strobe edge in between leaves `cyc_type` at 1 (row open) while the row is open and sets it to 5 (row-only refresh) at release. `dq_oe` stays 0 throughout.
- R5: A column strobe edge inside an open row with write enable inactive sets `cyc_type` to 2 (read). It pulses `arr_rd` and presents the word stored at {row, column} on `dq_out`, with `dq_oe` high.
- R6: If write enable is active at the column strobe edge, the cycle is an early write (`cyc_type` 3). `dq_in` is written to {row, column}, `arr_wr` pulses, and `dq_oe` stays 0 for the whole cycle.
- R7: If write enable becomes active while read data is held in a read cycle, `cyc_type` becomes 4 (read-modify-write). `dq_in` is written to the same location, and the output stays off until the next read. Before that edge, the old data is shown.
- R8: If the row strobe is released and asserted again while the column strobe stays active after a read, `cyc_type` becomes 7 (hidden refresh). `dq_out` and `dq_oe` keep the read data.
- R9: Held read data is dropped and `dq_oe` goes to 0 once both the row and column strobes are inactive, whichever of them rose last.
- R10: While read data is held, `dq_oe` is 0 whenever output enable is inactive or write enable is active, and returns when both are restored.
- R11: In page mode, releasing the column strobe while the row stays open leaves `dq_oe` and `dq_out` unchanged. `dq_out` changes only after the next column strobe edge.
- R12: A result caused by a pin change appears on the outputs after the third rising clock edge that follows the change. The `arr_rd` and `arr_wr` pulses last one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ROW_W | Multiplexed row/column address |
| dq_in | input | DW | Write data from the bus |
| dq_out | output | DW | Read data toward the bus |
| dq_oe | output | 1 | Drive enable for the data pins |
| cyc_type | output | 4 | Decoded cycle: 0 idle, 1 row open, 2 read, 3 early write, 4 read-modify-write, 5 row-only refresh, 6 column-first refresh, 7 hidden refresh, 8 test entry |
| test_mode | output | 1 | Test mode flag |
| arr_wr | output | 1 | One-clock pulse per array write |
| arr_rd | output | 1 | One-clock pulse per array read |

## Verification
A pin change reaches the synchronised level after two rising edges and acts at the third. Cycle type, held data and the array strobes therefore change after that third edge, while `dq_oe` follows output and write enable one edge sooner. The bench's vector walk applies each pin step at a falling edge and waits four clocks before it samples at a falling edge, so every result has settled. A directed test samples one read and one write at every falling edge and confirms that the pulse appears after the third edge and is gone after the fourth.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [3:0] {
    CY_IDLE   = 4'd0,
    CY_ROW    = 4'd1,
    CY_READ   = 4'd2,
    CY_EWR    = 4'd3,
    CY_RMW    = 4'd4,
    CY_RONLY  = 4'd5,
    CY_CBR    = 4'd6,
    CY_HIDDEN = 4'd7,
    CY_TEST   = 4'd8
  } cyc_e;
endpackage

// File: rtl/edo_pipe.sv
// Resettable register chain; used as the bus synchroniser.
module edo_pipe #(
  parameter int W = 1,
  parameter int DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/edo_array.sv
// Storage array: synchronous write, combinational read, no reset.
module edo_array #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder
  import edo_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  parameter int DW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic [3:0]       cyc_type,
  output logic             test_mode,
  output logic             arr_wr,
  output logic             arr_rd
);
  localparam int AW    = ROW_W + COL_W;
  localparam int BUS_W = ROW_W + DW;
  localparam int SYNC  = 2;

  // Synchronised strobes: [3] row, [2] column, [1] write, [0] output enable
  logic [3:0] strb_s;
  edo_pipe #(.W(4), .DEPTH(SYNC), .RST_VAL(4'hF)) u_strb (
    .clk(clk), .rst_n(rst_n), .d({ras_n, cas_n, we_n, oe_n}), .q(strb_s));

  // Address and data ride the same number of stages as the strobes
  logic [BUS_W-1:0] bus_s;
  edo_pipe #(.W(BUS_W), .DEPTH(SYNC), .RST_VAL('0)) u_bus (
    .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q(bus_s));

  logic [ROW_W-1:0] addr_s;
  logic [COL_W-1:0] col_in;
  logic [DW-1:0]    din_s;
  assign addr_s = bus_s[BUS_W-1:DW];
  assign din_s  = bus_s[DW-1:0];
  assign col_in = addr_s[COL_W-1:0];

  logic ras_act, cas_act, we_act, oe_act;
  assign {ras_act, cas_act, we_act, oe_act} = ~strb_s;

  logic [2:0] prev_act;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_act <= '0;
    else        prev_act <= {ras_act, cas_act, we_act};

  logic ras_fall, ras_rise, cas_fall, we_fall;
  assign ras_fall = ras_act  & ~prev_act[2];
  assign ras_rise = ~ras_act &  prev_act[2];
  assign cas_fall = cas_act  & ~prev_act[1];
  assign we_fall  = we_act   & ~prev_act[0];

  cyc_e             cyc_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             valid_q;
  logic [DW-1:0]    dout_q;
  logic             test_q, wr_q, rd_q;

  logic in_access, do_col, do_rmw, rd_en, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] rd_data;

  always_comb begin
    in_access = (cyc_q == CY_ROW) || (cyc_q == CY_READ) ||
                (cyc_q == CY_EWR) || (cyc_q == CY_RMW);
    do_col    = cas_fall && ras_act && !ras_fall && in_access;
    do_rmw    = we_fall && !do_col && !ras_fall && cas_act && ras_act &&
                valid_q && (cyc_q == CY_READ);
    rd_en     = do_col && !we_act;
    wr_en     = (do_col && we_act) || do_rmw;
    rd_addr   = {row_q, col_in};
    wr_addr   = do_col ? {row_q, col_in} : {row_q, col_q};
  end

  edo_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(din_s),
    .rd_addr(rd_addr), .rd_data(rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= CY_IDLE;
      row_q  <= '0;
      col_q  <= '0;
      test_q <= 1'b0;
    end else if (ras_fall) begin
      if (cas_act) begin
        if (we_act) begin
          cyc_q  <= CY_TEST;
          test_q <= 1'b1;
        end else if (valid_q) begin
          cyc_q <= CY_HIDDEN;
        end else begin
          cyc_q  <= CY_CBR;
          test_q <= 1'b0;
        end
      end else begin
        cyc_q <= CY_ROW;
        row_q <= addr_s;
      end
    end else if (ras_rise && cyc_q == CY_ROW) begin
      cyc_q  <= CY_RONLY;
      test_q <= 1'b0;
    end else if (do_col) begin
      col_q <= col_in;
      cyc_q <= we_act ? CY_EWR : CY_READ;
    end else if (do_rmw) begin
      cyc_q <= CY_RMW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dout_q  <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      wr_q <= wr_en;
      rd_q <= rd_en;
      if (rd_en) dout_q <= rd_data;
      if (!ras_act && !cas_act) valid_q <= 1'b0;
      else if (rd_en)           valid_q <= 1'b1;
      else if (wr_en)           valid_q <= 1'b0;
    end
  end

  assign dq_out    = dout_q;
  assign dq_oe     = valid_q & oe_act & ~we_act;
  assign cyc_type  = cyc_q;
  assign test_mode = test_q;
  assign arr_wr    = wr_q;
  assign arr_rd    = rd_q;
endmodule

// File: rtl/edo_cycle_decoder_chk.sv
module edo_cycle_decoder_chk
  import edo_pkg::*;
#(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_act,
  input logic          cas_act,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out,
  input logic [3:0]    cyc_type,
  input logic          test_mode,
  input logic          arr_wr,
  input logic          arr_rd
);
  // R9
  both_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_act && !cas_act) |=> !dq_oe);

  // R6
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> !dq_oe);

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_wr && arr_rd));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_rd |-> $stable(dq_out));

  // R3
  test_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> cyc_type == 4'(CY_TEST));

  // R4
  ronly_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 4'(CY_RONLY)) |-> !dq_oe);
endmodule

bind edo_cycle_decoder edo_cycle_decoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_act(ras_act), .cas_act(cas_act),
  .dq_oe(dq_oe), .dq_out(dq_out), .cyc_type(cyc_type),
  .test_mode(test_mode), .arr_wr(arr_wr), .arr_rd(arr_rd));

// File: tb/edo_cycle_decoder_test.sv
`timescale 1ns/1ps
module edo_cycle_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0] addr = '0;
  logic [3:0] dq_in = '0;
  logic [3:0] dq_out, cyc_type;
  logic dq_oe, test_mode, arr_wr, arr_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edo_cycle_decoder uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .cyc_type(cyc_type), .test_mode(test_mode), .arr_wr(arr_wr), .arr_rd(arr_rd));

  // Fields: req[24:21] pins{ras,cas,we,oe}[20:17] addr[16:14] din[13:10]
  //         type[9:6] oe[5] dout[4:1] test[0]
  localparam int NV = 33;
  localparam logic [24:0] VEC [NV] = '{
    {4'd4,  4'b0110, 3'd2, 4'h0, 4'd1, 1'b0, 4'h0, 1'b0}, // R4 row open
    {4'd6,  4'b0100, 3'd5, 4'h0, 4'd1, 1'b0, 4'h0, 1'b0}, // R6 W before column strobe
    {4'd6,  4'b0000, 3'd5, 4'hA, 4'd3, 1'b0, 4'h0, 1'b0}, // R6 early write A -> (2,5)
    {4'd6,  4'b0100, 3'd5, 4'hA, 4'd3, 1'b0, 4'h0, 1'b0},
    {4'd6,  4'b0000, 3'd6, 4'h3, 4'd3, 1'b0, 4'h0, 1'b0}, // R6 page write 3 -> (2,6)
    {4'd6,  4'b0110, 3'd6, 4'h3, 4'd3, 1'b0, 4'h0, 1'b0},
    {4'd6,  4'b1110, 3'd6, 4'h3, 4'd3, 1'b0, 4'h0, 1'b0},
    {4'd4,  4'b0110, 3'd2, 4'h3, 4'd1, 1'b0, 4'h0, 1'b0},
    {4'd5,  4'b0010, 3'd5, 4'h3, 4'd2, 1'b1, 4'hA, 1'b0}, // R5 read (2,5)
    {4'd11, 4'b0110, 3'd5, 4'h3, 4'd2, 1'b1, 4'hA, 1'b0}, // R11 precharge holds
    {4'd11, 4'b0010, 3'd6, 4'h3, 4'd2, 1'b1, 4'h3, 1'b0}, // R11 next page read
    {4'd10, 4'b0011, 3'd6, 4'h3, 4'd2, 1'b0, 4'h0, 1'b0}, // R10 OE off
    {4'd10, 4'b0010, 3'd6, 4'h3, 4'd2, 1'b1, 4'h3, 1'b0}, // R10 OE back
    {4'd7,  4'b0000, 3'd6, 4'hC, 4'd4, 1'b0, 4'h0, 1'b0}, // R7 RMW writes C
    {4'd7,  4'b0100, 3'd6, 4'hC, 4'd4, 1'b0, 4'h0, 1'b0},
    {4'd7,  4'b0110, 3'd6, 4'hC, 4'd4, 1'b0, 4'h0, 1'b0},
    {4'd7,  4'b0010, 3'd6, 4'hC, 4'd2, 1'b1, 4'hC, 1'b0}, // R7 same location now C
    {4'd8,  4'b1010, 3'd6, 4'hC, 4'd2, 1'b1, 4'hC, 1'b0}, // R8 row released, column held
    {4'd8,  4'b0010, 3'd6, 4'hC, 4'd7, 1'b1, 4'hC, 1'b0}, // R8 hidden refresh
    {4'd8,  4'b1010, 3'd6, 4'hC, 4'd7, 1'b1, 4'hC, 1'b0},
    {4'd9,  4'b1110, 3'd6, 4'hC, 4'd7, 1'b0, 4'h0, 1'b0}, // R9 column rises last
    {4'd2,  4'b1010, 3'd6, 4'hC, 4'd7, 1'b0, 4'h0, 1'b0},
    {4'd2,  4'b0010, 3'd6, 4'hC, 4'd6, 1'b0, 4'h0, 1'b0}, // R2 column-first refresh
    {4'd2,  4'b1110, 3'd6, 4'hC, 4'd6, 1'b0, 4'h0, 1'b0},
    {4'd3,  4'b1000, 3'd6, 4'hC, 4'd6, 1'b0, 4'h0, 1'b0},
    {4'd3,  4'b0000, 3'd6, 4'hC, 4'd8, 1'b0, 4'h0, 1'b1}, // R3 test entry
    {4'd3,  4'b1110, 3'd6, 4'hC, 4'd8, 1'b0, 4'h0, 1'b1},
    {4'd3,  4'b0110, 3'd1, 4'hC, 4'd1, 1'b0, 4'h0, 1'b1},
    {4'd4,  4'b1110, 3'd1, 4'hC, 4'd5, 1'b0, 4'h0, 1'b0}, // R4 row-only, R3 exit
    {4'd4,  4'b0110, 3'd2, 4'hC, 4'd1, 1'b0, 4'h0, 1'b0},
    {4'd5,  4'b0010, 3'd5, 4'hC, 4'd2, 1'b1, 4'hA, 1'b0},
    {4'd11, 4'b0110, 3'd5, 4'hC, 4'd2, 1'b1, 4'hA, 1'b0},
    {4'd9,  4'b1110, 3'd5, 4'hC, 4'd2, 1'b0, 4'h0, 1'b0}  // R9 row rises last
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp,
                     input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic pins(input logic [3:0] p);
    {ras_n, cas_n, we_n, oe_n} = p;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    wait_neg(3);
    // R1 reset state
    chk("R1", {4'd0, cyc_type}, 8'd0, "cyc_type");
    chk("R1", {4'd0, dq_oe, test_mode, arr_wr, arr_rd}, 8'd0, "flags");
    rst_n = 1'b1;
    wait_neg(4);
    chk("R1", {4'd0, cyc_type}, 8'd0, "cyc_type after release");
    oe_n = 1'b0;
    wait_neg(4);

    for (int v = 0; v < NV; v++) begin
      logic [24:0] e;
      e = VEC[v];
      pins(e[20:17]);
      addr  = e[16:14];
      dq_in = e[13:10];
      wait_neg(4);
      tag = $sformatf("R%0d step%0d", e[24:21], v);
      chk(tag, {4'd0, cyc_type}, {4'd0, e[9:6]}, "cyc_type");
      chk(tag, {7'd0, dq_oe}, {7'd0, e[5]}, "dq_oe");
      if (e[5]) chk(tag, {4'd0, dq_out}, {4'd0, e[4:1]}, "dq_out");
      chk(tag, {7'd0, test_mode}, {7'd0, e[0]}, "test_mode");
    end

    // R12 read latency: open row 2, column 6 holds C
    addr = 3'd2;
    pins(4'b0110);
    wait_neg(4);
    addr = 3'd6;
    pins(4'b0010);
    wait_neg(2);
    chk("R12", {6'd0, arr_rd, dq_oe}, 8'd0, "rd after 2 edges");
    wait_neg(1);
    chk("R12", {6'd0, arr_rd, dq_oe}, 8'd3, "rd after 3 edges");
    chk("R12", {4'd0, dq_out}, 8'hC, "dq_out after 3 edges");
    wait_neg(1);
    chk("R12", {7'd0, arr_rd}, 8'd0, "rd pulse width");
    pins(4'b1110);
    wait_neg(4);

    // R12 write latency, R6 no drive
    addr = 3'd2;
    pins(4'b0110);
    wait_neg(4);
    addr  = 3'd1;
    dq_in = 4'h5;
    pins(4'b0000);
    wait_neg(2);
    chk("R12", {7'd0, arr_wr}, 8'd0, "wr after 2 edges");
    wait_neg(1);
    chk("R12", {6'd0, arr_wr, dq_oe}, 8'd2, "wr after 3 edges");
    wait_neg(1);
    chk("R12", {7'd0, arr_wr}, 8'd0, "wr pulse width");
    pins(4'b0110);
    wait_neg(4);
    addr = 3'd1;
    pins(4'b0010);
    wait_neg(4);
    chk("R5", {4'd0, dq_out}, 8'h5, "read back of latency write");
    pins(4'b1110);
    wait_neg(4);

    // R1 reset in the middle of a read
    addr = 3'd2;
    pins(4'b0110);
    wait_neg(4);
    pins(4'b0010);
    wait_neg(4);
    rst_n = 1'b0;
    wait_neg(1);
    chk("R1", {4'd0, cyc_type}, 8'd0, "cyc_type in reset");
    chk("R1", {4'd0, dq_oe, test_mode, arr_wr, arr_rd}, 8'd0, "flags in reset");
    pins(4'b1111);
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule